// File: doc/BRIEF.md
# Limit-Reach Periodic Counter Timer

This block is a memory-mapped interval timer. A prescaler turns the system clock into a 500 ns tick. On each tick an up-counter advances by one unit. When the counter reaches a programmed limit, the block sets a sticky reached flag and raises an interrupt. On the following tick the counter reloads to zero, so the interrupt repeats with a period of limit + 1 ticks.

Register words are 32 bits wide. The count and the limit sit in bits 30:9 with the default parameters. Bits 8:0 always read as zero, and bit 31 carries the reached flag on counter reads. Software sets the period in one of two ways:
- writing the restarting limit word, which also clears the count and the interrupt;
- writing the keep-count limit word, which changes only the limit.

Reading the limit word acknowledges the interrupt. A limit of zero makes the counter run to the top of its range before it wraps.

The bus is a simple single-cycle register port: word address, read strobe, write strobe, write data and combinational read data. The port has no wait states.

Top module: `periodic_limit_timer`

## Requirements
- R1: After reset the count, the limit, the reached flag and the interrupt are all zero, and the counter is already running: with the default tick it reads one unit (bit CNT_LSB) after TICK_DIV clocks.
- R2: The counter advances by exactly one unit, that is bit CNT_LSB (bit 9 by default), once every TICK_DIV clocks, where TICK_DIV = CLK_KHZ*TICK_NS/1e6. Bits CNT_LSB-1:0 of a counter read are always zero.
- R3: A write to word 0 stores write data bits [CNT_LSB+CNT_W-1:CNT_LSB] as the limit (mask 0x7FFFFE00 by default). The same write clears the count and the prescaler phase and lowers the interrupt. It leaves the reached flag unchanged.
- R4: A write to word 2 stores the limit with the same mask. The count, the prescaler phase, the reached flag and the interrupt are all left unchanged.
- R5: A read of word 0 returns the stored limit in its field, with every other bit zero. The read also clears the reached flag and the interrupt.
- R6: A read of word 1 returns the count in bits [CNT_LSB+CNT_W-1:CNT_LSB] and the reached flag in bit 31. The read changes no state.
- R7: When a tick brings a nonzero limit's count to equal the limit, the reached flag and the interrupt are set. The next tick reloads the count to zero, so reaches repeat every limit+1 ticks.
- R8: With a limit of zero the counter runs up to its all-ones value (0x7FFFFE00 in the register by default). Reaching that value sets the reached flag and the interrupt, and the next tick wraps the count to zero.
- R9: Reads of words 2 to 7 return zero. Writes to words 1 and 3 to 7 change nothing.
- R10: If a limit is reached in the same cycle as a read of word 0, the new reach wins: the reached flag and the interrupt are set after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Word address of the register access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the cycle reg_rd is high |
| irq | output | 1 | Level interrupt, high after a reach until acknowledged |

## Verification
The hardest conditions to reach from the ports are the free-running wrap at the top of the count range and a reach that lands on the very cycle of a limit read. The first would take millions of ticks at the default width. The bench therefore narrows the count field to eight bits and shortens the tick to four clocks, which makes the wrap take about a thousand cycles. For the collision, each scenario starts from a restarting limit write, which zeroes the prescaler phase. The bench then counts clocks exactly from that write and places the word 0 read on the reaching edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // word addresses whose meaning the block decodes
   localparam int unsigned A_LIMIT_RESTART = 0;
   localparam int unsigned A_COUNT         = 1;
   localparam int unsigned A_LIMIT_KEEP    = 2;

   // derive the tick divide ratio from clock frequency and tick period
   function automatic longint unsigned tick_ratio(longint unsigned clk_khz,
                                                  longint unsigned tick_ns);
      return (clk_khz * tick_ns) / 64'd1000000;
   endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int unsigned DIV = 50
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("tmr_prescale: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_every_clock
         // every clock is a tick except the one that restarts the phase
         assign tick = !restart;
      end else begin : g_divider
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] phase_q;
         assign tick = (phase_q == LAST) && !restart;
         always_ff @(posedge clk) begin
            if (rst || restart) begin
               phase_q <= '0;
            end else if (phase_q == LAST) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int unsigned CNT_W = 22
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             load_restart,
   input  logic             load_keep,
   input  logic [CNT_W-1:0] lim_in,
   input  logic             ack,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] limit,
   output logic             reached,
   output logic             irq
);
   logic [CNT_W-1:0] cnt_q, lim_q, eff_lim, nxt;
   logic             rch_q, irq_q, reach;

   // a zero limit means run to the top of the range
   assign eff_lim = (lim_q == '0) ? {CNT_W{1'b1}} : lim_q;
   assign nxt     = (cnt_q == eff_lim) ? '0 : cnt_q + 1'b1;
   assign reach   = tick && !load_restart && (nxt == eff_lim);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         lim_q <= '0;
         rch_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (load_restart || load_keep) lim_q <= lim_in;

         if (load_restart)   cnt_q <= '0;
         else if (tick)      cnt_q <= nxt;

         if (reach)          rch_q <= 1'b1;
         else if (ack)       rch_q <= 1'b0;

         if (reach)                     irq_q <= 1'b1;
         else if (ack || load_restart)  irq_q <= 1'b0;
      end
   end

   assign count   = cnt_q;
   assign limit   = lim_q;
   assign reached = rch_q;
   assign irq     = irq_q;
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 22,
   parameter int unsigned CNT_LSB = 9
) (
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [CNT_W-1:0]  count,
   input  logic [CNT_W-1:0]  limit,
   input  logic              reached,
   output logic              load_restart,
   output logic              load_keep,
   output logic              ack,
   output logic [CNT_W-1:0]  lim_in,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam int unsigned TOP = CNT_LSB + CNT_W;

   logic sel_lim, sel_cnt, sel_keep;
   assign sel_lim  = (reg_addr == ADDR_W'(A_LIMIT_RESTART));
   assign sel_cnt  = (reg_addr == ADDR_W'(A_COUNT));
   assign sel_keep = (reg_addr == ADDR_W'(A_LIMIT_KEEP));

   assign load_restart = reg_wr && sel_lim;
   assign load_keep    = reg_wr && sel_keep;
   assign ack          = reg_rd && sel_lim;
   assign lim_in       = reg_wdata[TOP-1:CNT_LSB];

   // bits outside the limit field are dropped by the mask
   logic unused_wbits;
   assign unused_wbits = ^{reg_wdata[DATA_W-1:TOP], reg_wdata[CNT_LSB-1:0]};

   always_comb begin
      reg_rdata = '0;
      if (reg_rd && sel_lim) begin
         reg_rdata[TOP-1:CNT_LSB] = limit;
      end else if (reg_rd && sel_cnt) begin
         reg_rdata[TOP-1:CNT_LSB] = count;
         reg_rdata[DATA_W-1]      = reached;
      end
   end
endmodule

// File: rtl/periodic_limit_timer.sv
module periodic_limit_timer
   import tmr_pkg::*;
#(
   parameter int unsigned CLK_KHZ = 100000,
   parameter int unsigned TICK_NS = 500,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 22,
   parameter int unsigned CNT_LSB = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int unsigned TICK_DIV = int'(tick_ratio(CLK_KHZ, TICK_NS));

   generate
      if (TICK_DIV < 1) begin : g_bad_tick
         $error("periodic_limit_timer: tick period shorter than one clock");
      end
      if (CNT_LSB < 1 || CNT_W < 2 || CNT_LSB + CNT_W > DATA_W - 1) begin : g_bad_field
         $error("periodic_limit_timer: count field does not fit below the flag bit");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("periodic_limit_timer: address must reach word 2");
      end
   endgenerate

   logic             tick_w, load_restart_w, load_keep_w, ack_w, rch_w;
   logic [CNT_W-1:0] cnt_w, lim_w, lim_in_w;

   tmr_prescale #(.DIV(TICK_DIV)) u_pre (
      .clk     (clk),
      .rst     (rst),
      .restart (load_restart_w),
      .tick    (tick_w)
   );

   tmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk          (clk),
      .rst          (rst),
      .tick         (tick_w),
      .load_restart (load_restart_w),
      .load_keep    (load_keep_w),
      .lim_in       (lim_in_w),
      .ack          (ack_w),
      .count        (cnt_w),
      .limit        (lim_w),
      .reached      (rch_w),
      .irq          (irq)
   );

   tmr_regif #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .CNT_LSB(CNT_LSB)
   ) u_regs (
      .reg_addr     (reg_addr),
      .reg_rd       (reg_rd),
      .reg_wr       (reg_wr),
      .reg_wdata    (reg_wdata),
      .count        (cnt_w),
      .limit        (lim_w),
      .reached      (rch_w),
      .load_restart (load_restart_w),
      .load_keep    (load_keep_w),
      .ack          (ack_w),
      .lim_in       (lim_in_w),
      .reg_rdata    (reg_rdata)
   );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 22,
   parameter int unsigned CNT_LSB = 9
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_rd,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              irq,
   input logic              tick,
   input logic [CNT_W-1:0]  cnt,
   input logic              reached
);
   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
      reg_rd && reg_addr == ADDR_W'(1) |-> reg_rdata[CNT_LSB-1:0] == '0); // R2

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
      tick && !reg_wr |=> (cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)); // R2

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
      reg_wr && reg_addr == ADDR_W'(0) |=> cnt == '0 && !irq); // R3

   AST_KEEP_COUNT: assert property (@(posedge clk) disable iff (rst)
      reg_wr && reg_addr == ADDR_W'(2) && !tick |=> cnt == $past(cnt)); // R4

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      reg_rd && !reg_wr && reg_addr == ADDR_W'(0) && !tick |=> !irq && !reached); // R5

   AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
      irq |-> reached); // R7

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
      reg_rd && reg_addr > ADDR_W'(1) |-> reg_rdata == '0); // R9
endmodule

bind periodic_limit_timer tmr_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .CNT_LSB(CNT_LSB)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .reg_addr (reg_addr),
   .reg_rd   (reg_rd),
   .reg_wr   (reg_wr),
   .reg_rdata(reg_rdata),
   .irq      (irq),
   .tick     (tick_w),
   .cnt      (cnt_w),
   .reached  (rch_w)
);

// File: tb/periodic_limit_timer_test.sv
module periodic_limit_timer_test;
   localparam int unsigned DIV   = 4;        // 125000 kHz * 32 ns
   localparam int unsigned CW    = 8;
   localparam int unsigned LSB   = 9;
   localparam logic [31:0] FLAG  = 32'h8000_0000;
   localparam int unsigned TOPU  = (1 << CW) - 1;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  reg_addr = '0;
   logic        reg_rd = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   periodic_limit_timer #(
      .CLK_KHZ(125000), .TICK_NS(32), .ADDR_W(3),
      .DATA_W(32), .CNT_W(CW), .CNT_LSB(LSB)
   ) uut (
      .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   function automatic logic [31:0] u(int unsigned n);
      return 32'(n) << LSB;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all bus tasks enter and leave at a falling edge
   task automatic wr(int unsigned a, logic [31:0] d);
      reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(int unsigned a, output logic [31:0] d);
      reg_addr = 3'(a); reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      check("R1 irq after reset", {31'd0, irq}, 32'd0);
      rd(1, d); check("R1 count after reset", d, 32'd0);
      rd(0, d); check("R1 limit after reset", d, 32'd0);
      idle(DIV - 2);
      rd(1, d); check("R1 running after reset", d, u(1));
   endtask

   task automatic t_tick_and_mask;
      logic [31:0] d;
      wr(0, FLAG | u(100) | 32'h1FF | 32'h0F00_0000);
      idle(3 * DIV - 1);
      rd(1, d); check("R2 count before third tick", d, u(2));
      rd(1, d); check("R2 count after third tick", d, u(3));
      rd(0, d); check("R3 limit masked", d, u(100));
   endtask

   task automatic t_reach;
      logic [31:0] d;
      wr(0, u(5));
      idle(5 * DIV - 1);
      check("R7 irq before reach", {31'd0, irq}, 32'd0);
      idle(1);
      check("R7 irq at reach", {31'd0, irq}, 32'd1);
      rd(1, d); check("R7 count at reach", d, FLAG | u(5));
      check("R6 word1 read keeps irq", {31'd0, irq}, 32'd1);
      idle(DIV - 1);
      rd(1, d); check("R7 reload to zero", d, FLAG);
      rd(0, d); check("R5 limit read value", d, u(5));
      check("R5 irq cleared by read", {31'd0, irq}, 32'd0);
      rd(1, d); check("R5 flag cleared by read", d, 32'd0);
      idle(5 * DIV - 3);
      check("R7 second period reach", {31'd0, irq}, 32'd1);
      wr(0, u(5));
      check("R3 irq lowered by write", {31'd0, irq}, 32'd0);
      rd(1, d); check("R3 flag kept, count zero", d, FLAG);
      rd(0, d);
   endtask

   task automatic t_keep;
      logic [31:0] d;
      wr(0, u(50));
      idle(3 * DIV);
      wr(2, u(10) | 32'h8000_01FF);
      rd(1, d); check("R4 count unchanged", d, u(3));
      rd(0, d); check("R4 limit stored masked", d, u(10));
      idle(7 * DIV - 3);
      check("R4 reach at new limit", {31'd0, irq}, 32'd1);
      rd(0, d);
   endtask

   task automatic t_unused;
      logic [31:0] d;
      wr(0, u(50));
      wr(1, 32'h1234_5600);
      wr(3, 32'hFFFF_FFFF);
      rd(1, d); check("R9 write word1 ignored", d, 32'd0);
      rd(2, d); check("R9 read word2 zero", d, 32'd0);
      rd(3, d); check("R9 read word3 zero", d, 32'd0);
      rd(7, d); check("R9 read word7 zero", d, 32'd0);
      rd(0, d); check("R9 limit untouched", d, u(50));
   endtask

   task automatic t_free_run;
      logic [31:0] d;
      wr(0, 32'd0);
      idle(TOPU * DIV - 1);
      check("R8 irq before top", {31'd0, irq}, 32'd0);
      idle(1);
      check("R8 irq at top", {31'd0, irq}, 32'd1);
      rd(1, d); check("R8 count at top", d, FLAG | u(TOPU));
      idle(DIV - 1);
      rd(1, d); check("R8 wrap to zero", d, FLAG);
      rd(0, d);
   endtask

   task automatic t_collide;
      logic [31:0] d;
      wr(0, u(3));
      idle(3 * DIV - 1);
      rd(0, d); check("R10 limit read on reach edge", d, u(3));
      check("R10 reach wins irq", {31'd0, irq}, 32'd1);
      rd(1, d); check("R10 reach wins flag", d, FLAG | u(3));
   endtask

   initial begin
      idle(3);
      rst = 1'b0;
      t_reset();
      t_tick_and_mask();
      t_reach();
      t_keep();
      t_unused();
      t_free_run();
      t_collide();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      for (int i = 0; i < 50000; i++) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule